// File: doc/BRIEF.md
# Power-Fail Write Protect Controller

This block supervises a battery-backed static memory. External comparators report four supply levels: above the full-function level, below the write-protect trip level, above the battery-switch level and above the first-use arming level. The block turns these four flags into four outputs: a write-protect signal, a battery/main source select, an output-disable signal and a battery-armed flag. It also gates the host's chip, write and output enables before they reach the array.

Each comparator flag first passes through a two-flop synchronizer. It then passes through a filter that accepts a new value only after the value has held for `FILT_LEN` cycles. A five-state machine sits behind the filters, with the states sealed, protected, on-battery, recovering and normal. While the part is new, the battery path stays disconnected. It is armed the first time the supply passes the arming level, and it stays armed until a dedicated factory reset clears it. After the supply returns, access is granted only after `REC_CYCLES` cycles of recovery at full level.

Top module: `pfail_guard`

## Requirements
- R1: A change on a comparator flag that lasts fewer than `FILT_LEN` cycles has no effect on any output.
- R2: While `wprot` is 1, `ce_n_mem` and `we_n_mem` are 1. A write in progress is cut off in the same cycle that `wprot` rises.
- R3: While `out_dis` is 1, `oe_n_mem` is 1. `out_dis` is 1 whenever `wprot` is 1.
- R4: `bat_armed` becomes 1 once the arming flag `vcc_seal` is seen. Only `factory_rst_n` clears it; `rst_n` leaves it unchanged.
- R5: While `bat_armed` is 0, `src_bat` stays 0, even when the supply is below the battery-switch level.
- R6: When armed and `vcc_bat_ok` is 0, `src_bat` is 1. When `vcc_bat_ok` returns to 1, `src_bat` returns to 0.
- R7: After the supply reaches full level (`vcc_full`=1, `vcc_low`=0), `wprot` falls only after `REC_CYCLES` consecutive cycles at that level. If the full-level flag drops during recovery, the count restarts.
- R8: Hysteresis applies between the trip level and the full level. Normal operation continues there, and a protected part stays protected there.
- R9: While `wprot` is 0, `ce_n_mem`, `we_n_mem` and `oe_n_mem` follow `ce_n_in`, `we_n_in` and `oe_n_in`.
- R10: After `rst_n` or `factory_rst_n`, `wprot` and `out_dis` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Async active-low reset of the state machine and filters |
| factory_rst_n | input | 1 | Async active-low reset that also clears the arming bit |
| vcc_full | input | 1 | Supply above the full-function level |
| vcc_low | input | 1 | Supply below the write-protect trip level |
| vcc_bat_ok | input | 1 | Supply above the battery-switch level |
| vcc_seal | input | 1 | Supply above the first-use arming level |
| ce_n_in | input | 1 | Host chip enable, active low |
| we_n_in | input | 1 | Host write enable, active low |
| oe_n_in | input | 1 | Host output enable, active low |
| ce_n_mem | output | 1 | Gated chip enable to the array |
| we_n_mem | output | 1 | Gated write enable to the array |
| oe_n_mem | output | 1 | Gated output enable to the array |
| wprot | output | 1 | Write protection active |
| out_dis | output | 1 | Data outputs forced to high impedance |
| src_bat | output | 1 | 1 selects the battery, 0 the main supply |
| bat_armed | output | 1 | Battery backup armed |

## Verification
The assertions check, on every cycle, the relations that must always hold. Protection blocks chip and write enables, and disabling the outputs blocks output enable. Battery selection implies the battery is armed and protection is active. Normal operation implies the battery is armed, and the arming bit never falls outside factory reset. Some behaviours can only be shown by the bench's scenarios, because each depends on a history of supply levels. These are the filter's rejection of short pulses, the length of the recovery delay and its restart, the hysteresis band, and the arming bit surviving an ordinary reset.

// File: rtl/pfail_guard.sv
module pfail_guard #(
  parameter int FILT_LEN   = 8,
  parameter int REC_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic factory_rst_n,
  input  logic vcc_full,
  input  logic vcc_low,
  input  logic vcc_bat_ok,
  input  logic vcc_seal,
  input  logic ce_n_in,
  input  logic we_n_in,
  input  logic oe_n_in,
  output logic ce_n_mem,
  output logic we_n_mem,
  output logic oe_n_mem,
  output logic wprot,
  output logic out_dis,
  output logic src_bat,
  output logic bat_armed
);
  localparam int NFLAG = 4;
  localparam int FW = $clog2(FILT_LEN + 1);
  localparam int RW = $clog2(REC_CYCLES + 1);
  localparam logic [FW-1:0] FMAX = FW'(FILT_LEN - 1);
  localparam logic [RW-1:0] RMAX = RW'(REC_CYCLES - 1);
  localparam logic [NFLAG-1:0] SAFE = 4'b0010;

  typedef enum logic [2:0] {
    ST_SEALED, ST_OK, ST_PROT, ST_BATT, ST_REC
  } pstate_e;

  logic sys_rst_n;
  logic [NFLAG-1:0] raw, filt;
  logic f_full, f_low, f_bat, f_seal;
  pstate_e st;
  logic [RW-1:0] rcnt;
  logic armed_q;

  assign sys_rst_n = rst_n & factory_rst_n;
  assign raw = {vcc_seal, vcc_bat_ok, vcc_low, vcc_full};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flt
    logic s1, s2, f;
    logic [FW-1:0] cnt;
    always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
        s1 <= SAFE[g];
        s2 <= SAFE[g];
        f <= SAFE[g];
        cnt <= '0;
      end else begin
        s1 <= raw[g];
        s2 <= s1;
        if (s2 == f) begin
          cnt <= '0;
        end else if (cnt == FMAX) begin
          f <= s2;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
    assign filt[g] = f;
  end

  assign {f_seal, f_bat, f_low, f_full} = filt;

  always_ff @(posedge clk or negedge factory_rst_n) begin
    if (!factory_rst_n) armed_q <= 1'b0;
    else if (f_seal) armed_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      st <= ST_PROT;
      rcnt <= '0;
    end else begin
      unique case (st)
        ST_SEALED: if (armed_q) st <= ST_PROT;
        ST_PROT: begin
          rcnt <= '0;
          if (!armed_q) st <= ST_SEALED;
          else if (!f_bat) st <= ST_BATT;
          else if (f_full && !f_low) st <= ST_REC;
        end
        ST_BATT: if (f_bat) st <= ST_PROT;
        ST_REC: begin
          if (!f_full || f_low) begin
            st <= ST_PROT;
          end else if (rcnt == RMAX) begin
            st <= ST_OK;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
        ST_OK: if (f_low) st <= ST_PROT;
        default: st <= ST_PROT;
      endcase
    end
  end

  assign wprot = (st != ST_OK);
  assign out_dis = wprot;
  assign src_bat = (st == ST_BATT) && armed_q;
  assign bat_armed = armed_q;
  assign ce_n_mem = ce_n_in | wprot;
  assign we_n_mem = we_n_in | wprot;
  assign oe_n_mem = oe_n_in | out_dis;
endmodule

// File: rtl/pfail_guard_chk.sv
module pfail_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic factory_rst_n,
  input logic ce_n_in,
  input logic we_n_in,
  input logic oe_n_in,
  input logic ce_n_mem,
  input logic we_n_mem,
  input logic oe_n_mem,
  input logic wprot,
  input logic out_dis,
  input logic src_bat,
  input logic bat_armed
);
  p_wr_block_r2: assert property (@(posedge clk) disable iff (!rst_n || !factory_rst_n)
    wprot |-> (ce_n_mem && we_n_mem));
  p_out_block_r3: assert property (@(posedge clk) disable iff (!rst_n || !factory_rst_n)
    out_dis |-> oe_n_mem);
  p_prot_dis_r3: assert property (@(posedge clk) disable iff (!rst_n || !factory_rst_n)
    wprot |-> out_dis);
  p_arm_keep_r4: assert property (@(posedge clk) disable iff (!factory_rst_n)
    bat_armed |=> bat_armed);
  p_bat_armed_r5: assert property (@(posedge clk) disable iff (!rst_n || !factory_rst_n)
    src_bat |-> (bat_armed && wprot));
  p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n || !factory_rst_n)
    !wprot |-> (ce_n_mem == ce_n_in && we_n_mem == we_n_in && oe_n_mem == oe_n_in));
  p_ok_armed_r4: assert property (@(posedge clk) disable iff (!rst_n || !factory_rst_n)
    !wprot |-> bat_armed);
endmodule

bind pfail_guard pfail_guard_chk chk_i (
  .clk(clk), .rst_n(rst_n), .factory_rst_n(factory_rst_n),
  .ce_n_in(ce_n_in), .we_n_in(we_n_in), .oe_n_in(oe_n_in),
  .ce_n_mem(ce_n_mem), .we_n_mem(we_n_mem), .oe_n_mem(oe_n_mem),
  .wprot(wprot), .out_dis(out_dis), .src_bat(src_bat), .bat_armed(bat_armed)
);

// File: tb/pfail_guard_tb_top.sv
`timescale 1ns/1ps
module pfail_guard_tb_top;
  localparam int FL = 4;
  localparam int RC = 40;
  localparam int HOLD = FL + RC + 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0, factory_rst_n = 1'b0;
  logic vcc_full = 1'b0, vcc_low = 1'b1, vcc_bat_ok = 1'b0, vcc_seal = 1'b0;
  logic ce_n_in = 1'b1, we_n_in = 1'b1, oe_n_in = 1'b1;
  logic ce_n_mem, we_n_mem, oe_n_mem, wprot, out_dis, src_bat, bat_armed;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pfail_guard #(.FILT_LEN(FL), .REC_CYCLES(RC)) dut_i (
    .clk(clk), .rst_n(rst_n), .factory_rst_n(factory_rst_n),
    .vcc_full(vcc_full), .vcc_low(vcc_low), .vcc_bat_ok(vcc_bat_ok), .vcc_seal(vcc_seal),
    .ce_n_in(ce_n_in), .we_n_in(we_n_in), .oe_n_in(oe_n_in),
    .ce_n_mem(ce_n_mem), .we_n_mem(we_n_mem), .oe_n_mem(oe_n_mem),
    .wprot(wprot), .out_dis(out_dis), .src_bat(src_bat), .bat_armed(bat_armed));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // level 0: below battery switch, 1: below arming, 2: below trip, 3: below full, 4: full
  task automatic set_level(input int lv);
    vcc_full = (lv >= 4);
    vcc_low = (lv <= 2);
    vcc_bat_ok = (lv >= 1);
    vcc_seal = (lv >= 2);
  endtask

  function automatic logic [2:0] gate_exp(input logic prot, input logic c, input logic w, input logic o);
    return {c | prot, w | prot, o | prot};
  endfunction

  function automatic logic ok_exp(input logic prev_ok, input int lv);
    if (lv >= 4) return 1'b1;
    if (lv == 3) return prev_ok;
    return 1'b0;
  endfunction

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      chk("R2/R3/R9 gating", {29'd0, ce_n_mem, we_n_mem, oe_n_mem},
          {29'd0, gate_exp(wprot, ce_n_in, we_n_in, oe_n_in)});
      chk("R3 out_dis", {31'd0, out_dis}, {31'd0, wprot});
    end
  endtask

  task automatic wait_prot_ok_window(input string req);
    step(FL + RC);
    chk(req, {31'd0, wprot}, 32'd1);
    step(8);
    chk(req, {31'd0, wprot}, 32'd0);
  endtask

  initial begin
    logic model_ok, model_arm;
    int lv;
    void'($urandom(32'h5eed_1234));
    set_level(0);
    repeat (3) @(negedge clk);
    #1;
    chk("R10 wprot in reset", {31'd0, wprot}, 32'd1);
    chk("R10 out_dis in reset", {31'd0, out_dis}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1; factory_rst_n = 1'b1;
    step(20);
    chk("R5 unarmed no battery", {31'd0, src_bat}, 32'd0);
    chk("R4 unarmed at start", {31'd0, bat_armed}, 32'd0);
    set_level(1);
    step(20);
    chk("R4 below arming level", {31'd0, bat_armed}, 32'd0);
    set_level(0);
    step(20);
    chk("R5 unarmed still main", {31'd0, src_bat}, 32'd0);
    set_level(2);
    step(FL + 6);
    chk("R4 armed after seal level", {31'd0, bat_armed}, 32'd1);
    set_level(0);
    step(FL + 8);
    chk("R6 battery selected", {31'd0, src_bat}, 32'd1);
    set_level(2);
    step(FL + 8);
    chk("R6 back to main", {31'd0, src_bat}, 32'd0);
    chk("R7 still protected below trip", {31'd0, wprot}, 32'd1);

    set_level(4);
    wait_prot_ok_window("R7 recovery window");

    ce_n_in = 1'b0; we_n_in = 1'b0; oe_n_in = 1'b1;
    step(2);
    chk("R9 write passes", {31'd0, we_n_mem}, 32'd0);
    set_level(2);
    step(2);
    set_level(4);
    step(20);
    chk("R1 glitch ignored", {31'd0, wprot}, 32'd0);
    chk("R1 write still passes", {31'd0, we_n_mem}, 32'd0);
    set_level(3);
    step(HOLD);
    chk("R8 stays normal in band", {31'd0, wprot}, 32'd0);
    set_level(2);
    step(FL + 6);
    chk("R2 write cut off", {31'd0, we_n_mem}, 32'd1);
    chk("R2 chip enable cut off", {31'd0, ce_n_mem}, 32'd1);
    ce_n_in = 1'b1; we_n_in = 1'b1;
    set_level(3);
    step(HOLD);
    chk("R8 stays protected in band", {31'd0, wprot}, 32'd1);

    set_level(4);
    step(20);
    set_level(3);
    step(10);
    set_level(4);
    wait_prot_ok_window("R7 recovery restart");

    set_level(0);
    step(FL + 8);
    @(negedge clk); rst_n = 1'b0;
    step(2);
    chk("R10 wprot after rst", {31'd0, wprot}, 32'd1);
    rst_n = 1'b1;
    step(FL + 8);
    chk("R4 arming survives rst", {31'd0, bat_armed}, 32'd1);
    chk("R6 battery after rst", {31'd0, src_bat}, 32'd1);
    @(negedge clk); factory_rst_n = 1'b0;
    step(2);
    chk("R4 factory reset clears", {31'd0, bat_armed}, 32'd0);
    factory_rst_n = 1'b1;
    step(HOLD);
    chk("R5 cleared no battery", {31'd0, src_bat}, 32'd0);

    model_ok = 1'b0; model_arm = 1'b0;
    for (int k = 0; k < 30; k++) begin
      lv = $urandom_range(4, 0);
      if (k == 0) lv = 2;
      set_level(lv);
      for (int c = 0; c < HOLD; c++) begin
        ce_n_in = 1'($urandom); we_n_in = 1'($urandom); oe_n_in = 1'($urandom);
        step(1);
      end
      if (lv >= 2) model_arm = 1'b1;
      model_ok = ok_exp(model_ok, lv) && model_arm;
      chk("R7/R8 random settle", {31'd0, wprot}, {31'd0, !model_ok});
      chk("R6 random source", {31'd0, src_bat}, {31'd0, model_arm && lv == 0});
      chk("R4 random armed", {31'd0, bat_armed}, {31'd0, model_arm});
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule